// File: doc/BRIEF.md
# Memory-to-Memory Byte Move Sequencer

This block carries out a single-byte move from one memory location to another for an 8-bit microcontroller core. It always works in two steps. First it obtains the source byte, then it writes that byte to the destination. Operand bytes are taken from the instruction stream at the program counter. The block returns the advanced program counter, the possibly advanced 16-bit index pair, and a zero flag derived from the moved byte.

The surrounding core pulses a start strobe with a two-bit variant code, the current program counter and the index pair. The block owns a single-ported byte memory interface and makes one access per cycle. Read data is combinational: it must be valid in the same cycle as the address and is sampled on the next clock edge. When the write has completed, a one-cycle done pulse marks the point where the outputs hold the results. Decoding of the instruction and every flag other than zero stay with the caller.

Top module: `mem_move_seq`

## Requirements
- R1: Each accepted move performs exactly one memory write, and it comes after all of the move's reads. The written byte equals the source byte. Read and write strobes are never active together, and the block makes no access while idle.
- R2: Variant code 0 (direct to direct): the byte at PC is the source address and the byte at PC+1 is the destination address, both zero-extended to 16 bits. The final PC is PC+2 and the index pair is returned unchanged.
- R3: Variant code 1 (immediate to direct): the byte at PC is the value moved and the byte at PC+1 is the zero-extended destination address. The final PC is PC+2 and the index pair is unchanged.
- R4: Variant code 2 (indexed to direct): the source is read at the index pair and the byte at PC is the zero-extended destination address. The final PC is PC+1 and the returned index pair is the input plus one.
- R5: Variant code 3 (direct to indexed): the byte at PC is the zero-extended source address and the destination is the index pair. The final PC is PC+1 and the returned index pair is the input plus one.
- R6: The zero output is 1 when all eight bits of the moved byte are 0, and 0 otherwise.
- R7: A start with the word-size request high is illegal and is ignored. It causes no memory access and no done pulse, and it leaves the PC, index and zero outputs unchanged.
- R8: PC and index arithmetic is 16-bit and wraps from 0xFFFF to 0x0000. This applies both to operand fetches and to the returned values.
- R9: Done is high for exactly one cycle, the cycle after the write. Done is raised 5 cycles after the accepting edge for code 0 and 4 cycles after it for the other codes. The result outputs are valid while done is high and hold until the next move ends.
- R10: A start strobe that arrives while a move is in progress is ignored. The running move completes with its original inputs and no second move follows.
- R11: After reset, the PC, index and zero outputs are 0, done is 0, and no memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| word_req_i | input | 1 | Word-size request; makes a start illegal |
| mode_i | input | 2 | Variant code 0..3 (see R2-R5) |
| pc_i | input | 16 | Program counter pointing at the first operand byte |
| hx_i | input | 16 | Index register pair |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| pc_o | output | 16 | Program counter after the move |
| hx_o | output | 16 | Index pair after the move |
| z_o | output | 1 | Zero flag of the moved byte |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every variant is driven with random PC and index values over a memory whose contents are a fixed function of the address. This separates the variants by which operand byte is used as an address, which is used as data, and where the write lands. Directed moves force a zero source byte to set the flag and use a high-bit value to clear it. They also place the PC or the index pair at 0xFFFF, which shows whether the fetches and returned values wrap. A word-size start and a start injected mid-move show whether either is wrongly accepted, through stray accesses or extra done pulses.

// File: rtl/mv_pkg.sv
package mv_pkg;

  typedef enum logic [1:0] {
    MV_DD = 2'd0,
    MV_ID = 2'd1,
    MV_XD = 2'd2,
    MV_DX = 2'd3
  } mv_mode_e;

  typedef enum logic [2:0] {
    MV_IDLE  = 3'd0,
    MV_OPND1 = 3'd1,
    MV_OPND2 = 3'd2,
    MV_LOAD  = 3'd3,
    MV_STORE = 3'd4
  } mv_state_e;

  // first phase after an accepted start
  function automatic mv_state_e mv_first(input mv_mode_e m);
    return (m == MV_XD) ? MV_LOAD : MV_OPND1;
  endfunction

  // successor of a busy phase for the latched variant
  function automatic mv_state_e mv_next(input mv_state_e s, input mv_mode_e m);
    mv_state_e n;
    n = MV_IDLE;
    case (s)
      MV_OPND1: n = (m == MV_DX) ? MV_LOAD : MV_OPND2;
      MV_OPND2: n = (m == MV_DD) ? MV_LOAD : MV_STORE;
      MV_LOAD:  n = (m == MV_XD) ? MV_OPND2 : MV_STORE;
      default:  n = MV_IDLE;
    endcase
    return n;
  endfunction

  // variants whose indexed side advances the index pair
  function automatic logic mv_uses_idx(input mv_mode_e m);
    return (m == MV_XD) || (m == MV_DX);
  endfunction

endpackage

// File: rtl/mv_ctrl.sv
module mv_ctrl
  import mv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept_i,
  input  mv_mode_e  mode_i,
  output mv_state_e state_o,
  output mv_mode_e  mode_o
);

  mv_state_e state_q;
  mv_mode_e  mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      mode_q  <= MV_DD;
    end else if (accept_i) begin
      state_q <= mv_first(mode_i);
      mode_q  <= mode_i;
    end else if (state_q != MV_IDLE) begin
      state_q <= mv_next(state_q, mode_q);
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/mv_path.sv
module mv_path
  import mv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  mv_state_e         state_i,
  input  mv_mode_e          mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] hx_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] hx_base_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] hx_o,
  output logic              z_o,
  output logic              done_o
);

  localparam int PAD_W = ADDR_W - DATA_W;

  function automatic logic [ADDR_W-1:0] inc_wrap(input logic [ADDR_W-1:0] x);
    return x + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] page0(input logic [DATA_W-1:0] b);
    return {{PAD_W{1'b0}}, b};
  endfunction

  function automatic logic all_zero(input logic [DATA_W-1:0] b);
    return ~|b;
  endfunction

  logic [ADDR_W-1:0] ptr_q, hx_q;
  logic [DATA_W-1:0] src_q, dst_q, val_q;

  // address and strobes per phase
  always_comb begin
    addr_o = '0;
    rd_o   = 1'b0;
    wr_o   = 1'b0;
    case (state_i)
      MV_OPND1, MV_OPND2: begin
        addr_o = ptr_q;
        rd_o   = 1'b1;
      end
      MV_LOAD: begin
        addr_o = (mode_i == MV_XD) ? hx_q : page0(src_q);
        rd_o   = 1'b1;
      end
      MV_STORE: begin
        addr_o = (mode_i == MV_DX) ? hx_q : page0(dst_q);
        wr_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign wdata_o   = val_q;
  assign hx_base_o = hx_q;

  // operand capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      hx_q  <= '0;
      src_q <= '0;
      dst_q <= '0;
      val_q <= '0;
    end else if (accept_i) begin
      ptr_q <= pc_i;
      hx_q  <= hx_i;
    end else begin
      case (state_i)
        MV_OPND1: begin
          ptr_q <= inc_wrap(ptr_q);
          if (mode_i == MV_ID) val_q <= rdata_i;
          else                 src_q <= rdata_i;
        end
        MV_OPND2: begin
          ptr_q <= inc_wrap(ptr_q);
          dst_q <= rdata_i;
        end
        MV_LOAD: val_q <= rdata_i;
        default: ;
      endcase
    end
  end

  // results, published together with the done pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o   <= '0;
      hx_o   <= '0;
      z_o    <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= (state_i == MV_STORE);
      if (state_i == MV_STORE) begin
        pc_o <= ptr_q;
        hx_o <= mv_uses_idx(mode_i) ? inc_wrap(hx_q) : hx_q;
        z_o  <= all_zero(val_q);
      end
    end
  end

endmodule

// File: rtl/mem_move_seq.sv
module mem_move_seq
  import mv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              word_req_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] hx_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] hx_o,
  output logic              z_o,
  output logic              done_o
);

  mv_state_e         state_w;
  mv_mode_e          mode_q_w;
  logic              busy_w;
  logic              accept_w;
  logic [ADDR_W-1:0] hx_base_w;

  assign busy_w   = (state_w != MV_IDLE);
  assign accept_w = start_i && !word_req_i && !busy_w;

  mv_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept_i(accept_w),
    .mode_i  (mv_mode_e'(mode_i)),
    .state_o (state_w),
    .mode_o  (mode_q_w)
  );

  mv_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_w),
    .state_i  (state_w),
    .mode_i   (mode_q_w),
    .pc_i     (pc_i),
    .hx_i     (hx_i),
    .rdata_i  (mem_rdata_i),
    .addr_o   (mem_addr_o),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .wdata_o  (mem_wdata_o),
    .hx_base_o(hx_base_w),
    .pc_o     (pc_o),
    .hx_o     (hx_o),
    .z_o      (z_o),
    .done_o   (done_o)
  );

endmodule

// File: rtl/mv_checker.sv
module mv_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              word_req_i,
  input logic              busy,
  input logic              accept,
  input logic [1:0]        mode_q,
  input logic              rd,
  input logic              wr,
  input logic [DATA_W-1:0] wdata,
  input logic [ADDR_W-1:0] hx_base,
  input logic [ADDR_W-1:0] hx_o,
  input logic              z_o,
  input logic              done_o
);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd && wr)); // R1
  AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (rd || wr) |-> busy); // R1
  AST_WORD_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (start_i && word_req_i) |-> !accept); // R7
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !accept); // R10
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(mode_q)); // R10
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $past(wr)); // R9
  AST_WR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n) wr |=> done_o); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R9
  AST_Z_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (z_o == ($past(wdata) == '0))); // R6
  AST_HX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (done_o && mode_q[1]) |-> (hx_o == ADDR_W'($past(hx_base) + 1'b1))); // R4
  AST_HX_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !mode_q[1]) |-> (hx_o == $past(hx_base))); // R2

endmodule

bind mem_move_seq mv_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .word_req_i(word_req_i),
  .busy      (busy_w),
  .accept    (accept_w),
  .mode_q    (mode_q_w),
  .rd        (mem_rd_o),
  .wr        (mem_wr_o),
  .wdata     (mem_wdata_o),
  .hx_base   (hx_base_w),
  .hx_o      (hx_o),
  .z_o       (z_o),
  .done_o    (done_o)
);

// File: tb/sim_mem_move_seq.sv
`timescale 1ns/1ps
module sim_mem_move_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        word_req_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [15:0] pc_i = '0;
  logic [15:0] hx_i = '0;
  logic [7:0]  mem_rdata_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [15:0] pc_o, hx_o;
  logic        z_o, done_o;

  int errors = 0;
  int checks = 0;
  bit fin = 0;

  logic [15:0] ov_a [8];
  logic [7:0]  ov_d [8];
  int          ov_n = 0;

  always #2.5 clk = ~clk;

  mem_move_seq u0 (.*);

  function automatic logic [7:0] model(input logic [15:0] a);
    logic [7:0] r;
    r = a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) r = ov_d[i];
    return r;
  endfunction

  // read data settles mid-cycle, before the consuming edge
  always @(negedge clk) mem_rdata_i <= model(mem_addr_o);

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    ov_a[ov_n] = a;
    ov_d[ov_n] = d;
    ov_n++;
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic [15:0] pc, input logic [15:0] hx,
                        input bit inj, input string rq);
    logic [15:0] e_wa, e_pc, e_hx, wa;
    logic [7:0]  e_wd, s, wd;
    int          e_lat, n, nwr, wn;
    case (m)
      2'd0: begin s = model(pc); e_wd = model({8'h00, s}); e_wa = {8'h00, model(pc + 16'd1)};
                  e_pc = pc + 16'd2; e_hx = hx; e_lat = 5; end
      2'd1: begin e_wd = model(pc); e_wa = {8'h00, model(pc + 16'd1)};
                  e_pc = pc + 16'd2; e_hx = hx; e_lat = 4; end
      2'd2: begin e_wd = model(hx); e_wa = {8'h00, model(pc)};
                  e_pc = pc + 16'd1; e_hx = hx + 16'd1; e_lat = 4; end
      default: begin s = model(pc); e_wd = model({8'h00, s}); e_wa = hx;
                  e_pc = pc + 16'd1; e_hx = hx + 16'd1; e_lat = 4; end
    endcase
    @(negedge clk);
    start_i = 1'b1; word_req_i = 1'b0; mode_i = m; pc_i = pc; hx_i = hx;
    n = 0; nwr = 0; wn = 0; wa = '0; wd = '0;
    while (n < 20) begin
      @(negedge clk);
      n++;
      if (inj && n == 2) begin
        start_i = 1'b1; mode_i = ~m; pc_i = ~pc; hx_i = hx ^ 16'h1234;
      end else begin
        start_i = 1'b0;
      end
      if (mem_wr_o) begin nwr++; wa = mem_addr_o; wd = mem_wdata_o; wn = n; end
      if (done_o) break;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1 && n == e_lat, "R9", "done latency", n, e_lat);
    chk(nwr == 1 && wn == e_lat - 1, "R1", "single late write", nwr * 100 + wn, 100 + e_lat - 1);
    chk(wa == e_wa, rq, "write address", wa, e_wa);
    chk(wd == e_wd, "R1", "write data", wd, e_wd);
    chk(pc_o == e_pc, rq, "pc", pc_o, e_pc);
    chk(hx_o == e_hx, rq, "hx", hx_o, e_hx);
    chk(z_o == (e_wd == 8'h00), "R6", "zero flag", z_o, e_wd == 8'h00);
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done width", done_o, 0);
    if (inj) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!done_o && !mem_wr_o && !mem_rd_o, "R10", "no second move",
            {done_o, mem_wr_o, mem_rd_o}, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] p0, h0;
    int sd;
    sd = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(pc_o == 0 && hx_o == 0 && z_o == 0 && done_o == 0, "R11", "reset outputs",
        {pc_o, hx_o}, 0);
    chk(!mem_rd_o && !mem_wr_o, "R11", "reset strobes", {mem_rd_o, mem_wr_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 + R6: zero source sets the flag
    ov_n = 0; put(16'h1000, 8'h20); put(16'h1001, 8'h40); put(16'h0020, 8'h00);
    run_op(2'd0, 16'h1000, 16'hBEEF, 0, "R2");
    chk(z_o == 1'b1, "R6", "zero set", z_o, 1);
    // R3 + R6: high-bit immediate clears the flag
    ov_n = 0; put(16'h2000, 8'h80); put(16'h2001, 8'h55);
    run_op(2'd1, 16'h2000, 16'h0102, 0, "R3");
    chk(z_o == 1'b0, "R6", "zero clear", z_o, 0);
    // R4 + R8: index wraps
    ov_n = 0; put(16'hFFFF, 8'h00); put(16'h3000, 8'h77);
    run_op(2'd2, 16'h3000, 16'hFFFF, 0, "R4");
    chk(hx_o == 16'h0000, "R8", "index wrap", hx_o, 0);
    // R5 + R8: pc wraps
    ov_n = 0; put(16'hFFFF, 8'h33); put(16'h0033, 8'h01);
    run_op(2'd3, 16'hFFFF, 16'h4000, 0, "R5");
    chk(pc_o == 16'h0000, "R8", "pc wrap", pc_o, 0);
    // R8: two-byte operand fetch straddling the wrap
    ov_n = 0; put(16'hFFFF, 8'h11); put(16'h0000, 8'h22); put(16'h0011, 8'hA5);
    run_op(2'd0, 16'hFFFF, 16'h0000, 0, "R8");

    // R7: word-size start ignored
    p0 = pc_o; h0 = hx_o;
    @(negedge clk);
    start_i = 1'b1; word_req_i = 1'b1; mode_i = 2'd1; pc_i = 16'h5555; hx_i = 16'h6666;
    @(negedge clk);
    start_i = 1'b0; word_req_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk(!mem_rd_o && !mem_wr_o && !done_o, "R7", "no access on word start",
          {mem_rd_o, mem_wr_o, done_o}, 0);
      @(negedge clk);
    end
    chk(pc_o == p0 && hx_o == h0, "R7", "outputs held", {pc_o, hx_o}, {p0, h0});

    // R10: start during a busy move
    ov_n = 0;
    run_op(2'd0, 16'h7000, 16'h1111, 1, "R10");
    run_op(2'd2, 16'h7100, 16'h2222, 1, "R10");

    // random mix of all variants
    for (int i = 0; i < 60; i++) begin
      logic [1:0] m;
      logic [15:0] p, h;
      m = 2'($urandom % 4);
      p = 16'($urandom);
      h = 16'($urandom);
      ov_n = 0;
      if ($urandom % 4 == 0) begin
        put(p, 8'h00);
        if (m == 2'd2) put(h, 8'h00);
      end
      case (m)
        2'd0: run_op(m, p, h, 0, "R2");
        2'd1: run_op(m, p, h, 0, "R3");
        2'd2: run_op(m, p, h, 0, "R4");
        default: run_op(m, p, h, 0, "R5");
      endcase
    end

    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule